// File: doc/BRIEF.md
# Segment Hidden Base Register Unit

This block keeps the two 64-bit hidden base values that thread-local and per-processor addressing rely on, one for the FS segment and one for the GS segment. It accepts one write per cycle from any of three paths, and each path has its own rules.

A segment-register load supplies a 32-bit descriptor base. A privileged model-specific register write selects its target by a 32-bit address and supplies a full 64-bit value. A user-level base-write instruction supplies a 32-bit or a 64-bit operand. The block zero-extends where a path demands it. It also checks privilege, canonical form and the feature gate, and it reports a rejected write as a one-cycle coded fault pulse.

Address generation logic reads both bases directly. A debug or context-save path reads either base through a combinational read port.

Top module: `fsgs_base_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after its release, `fs_base` and `gs_base` read 0 and `fault` is low.
- R2: A segment load (`wr_kind`=1) with `sel_null`=0 writes the target base (`wr_target` 0=FS, 1=GS) with `wr_data[31:0]` in bits 31:0 and zero in bits 63:32. The new value is visible after the next rising clock edge.
- R3: A segment load with `sel_null`=1 leaves both bases unchanged and raises no fault.
- R4: A model-specific register write (`wr_kind`=2) at `cpl`=0 with a canonical value writes all 64 bits of `wr_data`. Address 32'hC000_0100 selects FS and 32'hC000_0101 selects GS, and `wr_target` is ignored.
- R5: A model-specific register write to either base address at `cpl`≠0 changes no base and pulses `fault` with `fault_code`=1 (privilege). This code takes priority over a non-canonical value.
- R6: A value is canonical when bits 63:47 all equal bit 47. A model-specific register write to a base address at `cpl`=0 with a non-canonical value changes no base and pulses `fault` with `fault_code`=2.
- R7: A model-specific register write to any other address changes no base and raises no fault, at any `cpl`.
- R8: A user base write (`wr_kind`=3) with `feat_en`=1 and `long_mode`=1 succeeds at any `cpl`. With `op64`=1 it writes all 64 bits of `wr_data`. With `op64`=0 it writes `wr_data[31:0]` and clears bits 63:32.
- R9: A user base write with `feat_en`=0 or `long_mode`=0 changes no base and pulses `fault` with `fault_code`=3.
- R10: `fault` and `fault_code` are registered and appear in the cycle after the offending strobe, for that one cycle only. An idle cycle (`wr_kind`=0) or a successful write is followed by `fault`=0 and `fault_code`=0.
- R11: `rd_data` shows `fs_base` when `rd_sel`=0 and `gs_base` when `rd_sel`=1, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_kind | input | 2 | Write strobe/type: 0 idle, 1 segment load, 2 model-specific register write, 3 user base write |
| wr_target | input | 1 | Target for kinds 1 and 3: 0 FS, 1 GS |
| sel_null | input | 1 | Segment load carries a null selector |
| cpl | input | 2 | Current privilege level |
| feat_en | input | 1 | User base-write feature enable |
| long_mode | input | 1 | Core is in 64-bit mode |
| op64 | input | 1 | User base write operand is 64 bits |
| msr_addr | input | 32 | Model-specific register address |
| wr_data | input | 64 | Write data |
| fs_base | output | 64 | FS hidden base |
| gs_base | output | 64 | GS hidden base |
| fault | output | 1 | One-cycle fault pulse |
| fault_code | output | 2 | 0 none, 1 privilege, 2 non-canonical, 3 feature disabled |
| rd_sel | input | 1 | Read port select: 0 FS, 1 GS |
| rd_data | output | 64 | Selected base |

## Verification
The bench runs a segment load after a model-specific register write has filled the upper half. A design that merged the low word into the old value instead of zero-extending it would keep stale upper bits. It probes the canonical boundary on both sides of bit 47, including values that differ from canonical form in a single bit. A sign test on the wrong bit would either accept these values or reject legal kernel-half addresses. It pairs privilege violations with non-canonical data, where a wrong priority reports code 2. It sends writes to non-base addresses at user level, where a design that decoded too loosely would fault or write. It also checks user writes with the gate closed by each input alone, and a null segment load. A design that got these wrong would corrupt a base that must survive.

// File: rtl/fsgs_pkg.sv
// Package: shared encodings for the segment hidden base unit.
// Assumes a two-bit write-kind strobe and a two-bit fault code.
package fsgs_pkg;

    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_SEG  = 2'd1,
        WK_MSR  = 2'd2,
        WK_USR  = 2'd3
    } wr_kind_e;

    typedef enum logic [1:0] {
        FC_NONE    = 2'd0,
        FC_PRIV    = 2'd1,
        FC_NONCANO = 2'd2,
        FC_DISABLE = 2'd3
    } fault_code_e;

    localparam int unsigned SEG_FS = 0;
    localparam int unsigned SEG_GS = 1;

endpackage

// File: rtl/fsgs_canon_chk.sv
// Module: canonical-form test for a virtual address.
// A value is canonical when every bit from VA_W-1 up to DATA_W-1 is equal.
// Assumes VA_W < DATA_W.
module fsgs_canon_chk #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned VA_W   = 48
) (
    input  logic [DATA_W-1:0] value,
    output logic              canonical
);
    localparam int unsigned TOP_W = DATA_W - VA_W + 1;

    logic [TOP_W-1:0] top_bits;

    // Purpose: gather the sign-extension field including the sign bit.
    always_comb begin
        top_bits  = value[DATA_W-1:VA_W-1];
        canonical = (&top_bits) | (~|top_bits);
    end
endmodule

// File: rtl/fsgs_write_decode.sv
// Module: decodes one write request into per-segment enables, a write value
// and a fault. Purely combinational; the caller registers the results.
// Assumes at most one request per cycle and NUM_SEG == 2 (FS, GS).
module fsgs_write_decode
    import fsgs_pkg::*;
#(
    parameter int unsigned DATA_W      = 64,
    parameter int unsigned LOAD_W      = 32,
    parameter int unsigned VA_W        = 48,
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned NUM_SEG     = 2,
    parameter logic [ADDR_W-1:0] FS_ADDR = 32'hC000_0100,
    parameter logic [ADDR_W-1:0] GS_ADDR = 32'hC000_0101
) (
    input  logic [1:0]         wr_kind,
    input  logic               wr_target,
    input  logic               sel_null,
    input  logic [1:0]         cpl,
    input  logic               feat_en,
    input  logic               long_mode,
    input  logic               op64,
    input  logic [ADDR_W-1:0]  msr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [NUM_SEG-1:0] seg_we,
    output logic [DATA_W-1:0]  seg_wval,
    output logic               flt_set,
    output logic [1:0]         flt_code
);
    localparam int unsigned PAD_W = DATA_W - LOAD_W;

    wr_kind_e          kind;
    logic              canon_ok;
    logic              hit_fs;
    logic              hit_gs;
    logic [DATA_W-1:0] zext_val;

    fsgs_canon_chk #(
        .DATA_W (DATA_W),
        .VA_W   (VA_W)
    ) u_canon (
        .value     (wr_data),
        .canonical (canon_ok)
    );

    // Purpose: decode the kind and form the zero-extended narrow value.
    always_comb begin
        kind     = wr_kind_e'(wr_kind);
        hit_fs   = (msr_addr == FS_ADDR);
        hit_gs   = (msr_addr == GS_ADDR);
        zext_val = {{PAD_W{1'b0}}, wr_data[LOAD_W-1:0]};
    end

    // Purpose: apply the per-path rules for enables, value and fault.
    always_comb begin
        seg_we   = '0;
        seg_wval = wr_data;
        flt_set  = 1'b0;
        flt_code = FC_NONE;
        unique case (kind)
            WK_SEG: begin
                if (!sel_null) begin
                    seg_we[wr_target] = 1'b1;
                    seg_wval          = zext_val;
                end
            end
            WK_MSR: begin
                if (hit_fs || hit_gs) begin
                    if (cpl != 2'd0) begin
                        flt_set  = 1'b1;
                        flt_code = FC_PRIV;
                    end else if (!canon_ok) begin
                        flt_set  = 1'b1;
                        flt_code = FC_NONCANO;
                    end else begin
                        seg_we[hit_gs ? SEG_GS : SEG_FS] = 1'b1;
                    end
                end
            end
            WK_USR: begin
                if (!feat_en || !long_mode) begin
                    flt_set  = 1'b1;
                    flt_code = FC_DISABLE;
                end else begin
                    seg_we[wr_target] = 1'b1;
                    seg_wval          = op64 ? wr_data : zext_val;
                end
            end
            default: begin
                seg_we = '0;
            end
        endcase
    end
endmodule

// File: rtl/fsgs_base_reg.sv
// Module: one hidden base register with write enable.
// Assumes synchronous active-low reset to zero.
module fsgs_base_reg #(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wval,
    output logic [DATA_W-1:0] q
);
    // Purpose: hold the base, load on enable, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wval;
        end
    end
endmodule

// File: rtl/fsgs_fault_reg.sv
// Module: registers the fault strobe and code as a one-cycle pulse.
// Assumes the decoder raises flt_set for exactly the offending cycle.
module fsgs_fault_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flt_set,
    input  logic [1:0] flt_code,
    output logic       fault,
    output logic [1:0] fault_code
);
    // Purpose: capture this cycle's fault, clear when none.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault      <= 1'b0;
            fault_code <= 2'd0;
        end else begin
            fault      <= flt_set;
            fault_code <= flt_set ? flt_code : 2'd0;
        end
    end

    // R10
    code_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code != 2'd0) == fault);
endmodule

// File: rtl/fsgs_base_unit.sv
// Module: top of the segment hidden base unit. Holds FS and GS bases and
// applies segment-load, model-specific register and user base-write rules.
// Assumes one write request per cycle; results appear after the next edge.
module fsgs_base_unit
    import fsgs_pkg::*;
#(
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned LOAD_W  = 32,
    parameter int unsigned VA_W    = 48,
    parameter int unsigned ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] FS_ADDR = 32'hC000_0100,
    parameter logic [ADDR_W-1:0] GS_ADDR = 32'hC000_0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        wr_kind,
    input  logic              wr_target,
    input  logic              sel_null,
    input  logic [1:0]        cpl,
    input  logic              feat_en,
    input  logic              long_mode,
    input  logic              op64,
    input  logic [ADDR_W-1:0] msr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] fs_base,
    output logic [DATA_W-1:0] gs_base,
    output logic              fault,
    output logic [1:0]        fault_code,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned NUM_SEG = 2;
    localparam int unsigned PAD_W   = DATA_W - LOAD_W;

    logic [NUM_SEG-1:0] seg_we;
    logic [DATA_W-1:0]  seg_wval;
    logic               flt_set;
    logic [1:0]         flt_code;
    logic [DATA_W-1:0]  seg_base [NUM_SEG];

    fsgs_write_decode #(
        .DATA_W  (DATA_W),
        .LOAD_W  (LOAD_W),
        .VA_W    (VA_W),
        .ADDR_W  (ADDR_W),
        .NUM_SEG (NUM_SEG),
        .FS_ADDR (FS_ADDR),
        .GS_ADDR (GS_ADDR)
    ) u_dec (
        .wr_kind   (wr_kind),
        .wr_target (wr_target),
        .sel_null  (sel_null),
        .cpl       (cpl),
        .feat_en   (feat_en),
        .long_mode (long_mode),
        .op64      (op64),
        .msr_addr  (msr_addr),
        .wr_data   (wr_data),
        .seg_we    (seg_we),
        .seg_wval  (seg_wval),
        .flt_set   (flt_set),
        .flt_code  (flt_code)
    );

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        fsgs_base_reg #(
            .DATA_W (DATA_W)
        ) u_base (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (seg_we[s]),
            .wval  (seg_wval),
            .q     (seg_base[s])
        );
    end

    fsgs_fault_reg u_flt (
        .clk        (clk),
        .rst_n      (rst_n),
        .flt_set    (flt_set),
        .flt_code   (flt_code),
        .fault      (fault),
        .fault_code (fault_code)
    );

    // Purpose: expose both bases and the selected one on the read port.
    always_comb begin
        fs_base = seg_base[SEG_FS];
        gs_base = seg_base[SEG_GS];
        rd_data = seg_base[rd_sel];
    end

    // R2
    seg_load_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == WK_SEG && !sel_null && !wr_target) |=>
        (fs_base == {{PAD_W{1'b0}}, $past(wr_data[LOAD_W-1:0])}));

    // R3
    null_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == WK_SEG && sel_null) |=>
        ($stable(fs_base) && $stable(gs_base) && !fault));

    // R5
    msr_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == WK_MSR && (msr_addr == FS_ADDR || msr_addr == GS_ADDR) && cpl != 2'd0) |=>
        (fault && fault_code == FC_PRIV && $stable(fs_base) && $stable(gs_base)));

    // R7
    msr_other_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == WK_MSR && msr_addr != FS_ADDR && msr_addr != GS_ADDR) |=>
        (!fault && $stable(fs_base) && $stable(gs_base)));

    // R9
    usr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == WK_USR && !(feat_en && long_mode)) |=>
        (fault && fault_code == FC_DISABLE && $stable(fs_base) && $stable(gs_base)));

    // R10
    idle_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == WK_IDLE) |=> (!fault && $stable(fs_base) && $stable(gs_base)));
endmodule

// File: tb/tb_fsgs_base_unit.sv
`timescale 1ns/1ps
module tb_fsgs_base_unit;

    typedef struct {
        logic [63:0] fs;
        logic [63:0] gs;
        logic        flt;
        logic [1:0]  code;
        logic [63:0] rd;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wr_kind = 2'd0;
    logic        wr_target = 1'b0;
    logic        sel_null = 1'b0;
    logic [1:0]  cpl = 2'd0;
    logic        feat_en = 1'b0;
    logic        long_mode = 1'b0;
    logic        op64 = 1'b0;
    logic [31:0] msr_addr = 32'd0;
    logic [63:0] wr_data = 64'd0;
    logic        rd_sel = 1'b0;
    logic [63:0] fs_base, gs_base, rd_data;
    logic        fault;
    logic [1:0]  fault_code;

    int   n_vec = 0;
    int   n_bad = 0;
    exp_t q[$];
    logic [63:0] m_fs = 64'd0;
    logic [63:0] m_gs = 64'd0;

    localparam logic [31:0] A_FS = 32'hC000_0100;
    localparam logic [31:0] A_GS = 32'hC000_0101;

    always #2.5 clk = ~clk;

    fsgs_base_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_kind(wr_kind), .wr_target(wr_target),
        .sel_null(sel_null), .cpl(cpl), .feat_en(feat_en), .long_mode(long_mode),
        .op64(op64), .msr_addr(msr_addr), .wr_data(wr_data),
        .fs_base(fs_base), .gs_base(gs_base), .fault(fault),
        .fault_code(fault_code), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    function automatic logic canon(input logic [63:0] v);
        return (v[63:47] == 17'h1FFFF) || (v[63:47] == 17'h0);
    endfunction

    // Driver: applies one request at a falling edge and queues the expectation.
    task automatic do_op(input logic [1:0] k, input logic tg, input logic nl,
                         input logic [1:0] pl, input logic fe, input logic lm,
                         input logic o64, input logic [31:0] ad,
                         input logic [63:0] d, input logic rs, input string tag);
        exp_t e;
        logic       f = 1'b0;
        logic [1:0] c = 2'd0;
        @(negedge clk);
        wr_kind = k; wr_target = tg; sel_null = nl; cpl = pl; feat_en = fe;
        long_mode = lm; op64 = o64; msr_addr = ad; wr_data = d; rd_sel = rs;
        case (k)
            2'd1: if (!nl) begin
                if (tg) m_gs = {32'd0, d[31:0]}; else m_fs = {32'd0, d[31:0]};
            end
            2'd2: if (ad == A_FS || ad == A_GS) begin
                if (pl != 0)       begin f = 1'b1; c = 2'd1; end
                else if (!canon(d)) begin f = 1'b1; c = 2'd2; end
                else if (ad == A_GS) m_gs = d;
                else                 m_fs = d;
            end
            2'd3: if (!fe || !lm) begin f = 1'b1; c = 2'd3; end
                  else begin
                      if (tg) m_gs = o64 ? d : {32'd0, d[31:0]};
                      else    m_fs = o64 ? d : {32'd0, d[31:0]};
                  end
            default: ;
        endcase
        e.fs = m_fs; e.gs = m_gs; e.flt = f; e.code = c;
        e.rd = rs ? m_gs : m_fs; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input logic rs, input string tag);
        do_op(2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'd0, 64'd0, rs, tag);
    endtask

    // Monitor: after each rising edge, compares the design with the oldest item.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (fs_base !== e.fs || gs_base !== e.gs || fault !== e.flt ||
                fault_code !== e.code || rd_data !== e.rd) begin
                n_bad++;
                $display("FAIL %s: got fs=%h gs=%h flt=%b code=%0d rd=%h exp fs=%h gs=%h flt=%b code=%0d rd=%h",
                         e.tag, fs_base, gs_base, fault, fault_code, rd_data,
                         e.fs, e.gs, e.flt, e.code, e.rd);
            end
        end
    end

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: got hung run exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state observed during reset
        n_vec++;
        if (fs_base !== 64'd0 || gs_base !== 64'd0 || fault !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got fs=%h gs=%h flt=%b exp 0 0 0", fs_base, gs_base, fault);
        end
        rst_n = 1'b1;
        idle(1'b0, "R1");
        // R2: segment load zero-extends
        do_op(2'd1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 32'd0, 64'hDEAD_BEEF_1234_5678, 1'b0, "R2");
        do_op(2'd1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'd0, 64'hFFFF_FFFF_8765_4321, 1'b1, "R2");
        // R3: null selector holds
        do_op(2'd1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 32'd0, 64'h1111_2222_3333_4444, 1'b1, "R3");
        do_op(2'd1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 32'd0, 64'h5555_6666_7777_8888, 1'b0, "R3");
        // R4: privileged writes, target input ignored
        do_op(2'd2, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, A_FS, 64'h0000_7FFF_FFFF_0000, 1'b0, "R4");
        do_op(2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, A_GS, 64'hFFFF_8000_0000_0000, 1'b1, "R4");
        // R2: segment load clears upper half written above
        do_op(2'd1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'd0, 64'hAAAA_AAAA_0000_00F0, 1'b1, "R2");
        do_op(2'd2, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, A_GS, 64'hFFFF_FFFF_FFFF_FFF8, 1'b1, "R4");
        // R5: privilege fault, and priority over non-canonical
        do_op(2'd2, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, A_FS, 64'h0000_0000_0000_1000, 1'b0, "R5");
        do_op(2'd2, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, A_GS, 64'h8000_0000_0000_0000, 1'b1, "R5");
        // R10: pulse ends after an idle cycle
        idle(1'b0, "R10");
        // R6: non-canonical boundaries
        do_op(2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, A_FS, 64'h0000_8000_0000_0000, 1'b0, "R6");
        do_op(2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, A_GS, 64'hFFFF_7FFF_FFFF_FFFF, 1'b1, "R6");
        do_op(2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, A_FS, 64'h0001_0000_0000_0000, 1'b0, "R6");
        // R10: successful write right after a fault clears the pulse
        do_op(2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, A_FS, 64'h0000_7FFF_FFFF_FFFF, 1'b0, "R10");
        // R7: other addresses ignored at any privilege
        do_op(2'd2, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 32'hC000_0102, 64'h0000_0000_0000_0001, 1'b0, "R7");
        do_op(2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h4000_0100, 64'h8000_0000_0000_0000, 1'b1, "R7");
        // R8: user writes at user privilege
        do_op(2'd3, 1'b0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b1, 32'd0, 64'h1234_5678_9ABC_DEF0, 1'b0, "R8");
        do_op(2'd3, 1'b1, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 32'd0, 64'hCAFE_F00D_0BAD_BEEF, 1'b1, "R8");
        // R9: gate closed by each input
        do_op(2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 32'd0, 64'h0, 1'b0, "R9");
        do_op(2'd3, 1'b1, 1'b0, 2'd3, 1'b1, 1'b0, 1'b1, 32'd0, 64'h0, 1'b1, "R9");
        // R11: read port follows select
        idle(1'b0, "R11");
        idle(1'b1, "R11");
        idle(1'b0, "R11");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule